// File: doc/BRIEF.md
# Pixel Sampling Timing Sequencer

The sequencer produces the digital timing for a three-channel video front end. The front end has one shared converter. All activity is on the rising master clock edge. A per-pixel sync pulse re-anchors every pixel sequence. In colour operation, one sample strobe latches all three channels at the same time. The converter then takes them in the fixed order red, green, blue. Each conversion slot is two master clock cycles long, so the converter runs at three times the pixel rate. In monochrome operation, a single configured channel feeds the converter continuously, with one conversion per slot.

One configuration word is written through a simple write port. It selects colour or monochrome, the monochrome channel, correlated double sampling, output inversion and standby. A written word is held pending and is applied only at the next sync pulse. The converter result returns on a data port. The block registers that word, complements it when inversion is active, and adds a channel tag so downstream logic can de-interleave colour pixels.

Top module: `pxseq_top`

## Requirements
- R1: While reset is active and after its release, until the first sync, `samp_o`, `conv_o`, `mux_sel_o`, `cds_o` and `data_valid_o` are all zero.
- R2: When `sync_i` is high at a clock edge and the pending word has standby clear, then in the following cycle `conv_o` is 1. In colour mode that cycle also has `samp_o` = 3'b111 and `mux_sel_o` = 0.
- R3: In colour mode, cycles 1 to 6 after the sync edge drive `mux_sel_o` = 0,0,1,1,2,2 (0 = red, 1 = green, 2 = blue). `conv_o` is high in cycles 1, 3 and 5 only, and `samp_o` is high in cycle 1 only. From cycle 7 until the next sync, all strobes are low and `mux_sel_o` is 0.
- R4: `conv_o` is never high in two consecutive cycles. While a sequence runs, it pulses exactly every second cycle.
- R5: A sync during a running colour sequence abandons it. The next cycle restarts at cycle 1 of R3.
- R6: In monochrome mode, after a sync, `conv_o` pulses every second cycle without end. `mux_sel_o` equals the configured channel. `samp_o` is the one-hot bit of that channel and coincides with `conv_o`. A channel field of 3 is treated as 2.
- R7: A configuration write has no visible effect until the next sync edge. A write and a sync at the same edge apply the previously pending word.
- R8: While the applied word has standby set, `samp_o` and `conv_o` stay zero.
- R9: A cycle after `adc_valid_i` is high at an edge, `data_valid_o` is 1. `data_o` is the captured word, bitwise complemented when the applied invert bit is set.
- R10: `data_tag_o` gives the channel of the latest conversion strobe, including one in the same cycle as `adc_valid_i`.
- R11: `cds_o` follows the cds bit of the applied configuration word.
- R12: Configuration word fields: bit 0 monochrome, bits 2:1 monochrome channel, bit 3 invert, bit 4 standby, bit 5 cds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, twice the conversion rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Per-pixel sync pulse |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 6 | Configuration word |
| adc_valid_i | input | 1 | Converter result valid |
| adc_data_i | input | DATA_W | Converter result |
| samp_o | output | 3 | Per-channel sample strobes (bit 0 red) |
| conv_o | output | 1 | Conversion start strobe |
| mux_sel_o | output | 2 | Channel routed to the converter |
| cds_o | output | 1 | Correlated double sampling mode active |
| data_valid_o | output | 1 | Output word valid |
| data_o | output | DATA_W | Output word, optionally inverted |
| data_tag_o | output | 2 | Channel tag of output word |

## Verification
The bench targets a sync that lands in the middle of a colour sequence. A design that ignored it would finish the old pixel and lose alignment. It also targets a configuration write made in the middle of a pixel. A design that applied it at once would switch mode or channel inside the sequence. A data return in the same cycle as a conversion strobe checks that the tag does not lag one channel behind. A monochrome channel field of 3 checks that the mux never selects a channel that does not exist. Random syncs, writes and data returns are compared cycle by cycle against a bench model that is built on a cycle-since-sync count rather than on slot and phase counters.

// File: rtl/pxseq_pkg.sv
package pxseq_pkg;
  localparam int NUM_CH = 3;
  localparam int CH_W   = 2;

  typedef struct packed {
    logic            cds;
    logic            standby;
    logic            invert;
    logic [CH_W-1:0] mono_ch;
    logic            mono;
  } cfg_t;
endpackage

// File: rtl/pxseq_cfg.sv
module pxseq_cfg
  import pxseq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  input  logic we_i,
  input  cfg_t wdata_i,
  output cfg_t pend_o,
  output cfg_t act_o
);
  cfg_t pend_q, act_q, wr_fix;

  // clamp channel to the last existing one
  always_comb begin
    wr_fix = wdata_i;
    if (wdata_i.mono_ch > CH_W'(NUM_CH-1)) wr_fix.mono_ch = CH_W'(NUM_CH-1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      if (we_i)   pend_q <= wr_fix;
      if (sync_i) act_q  <= pend_q;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

  // R7
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> $stable(act_q));
  // R6
  ch_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_q.mono_ch <= CH_W'(NUM_CH-1));
endmodule

// File: rtl/pxseq_timer.sv
module pxseq_timer
  import pxseq_pkg::*;
#(
  parameter int SLOT_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  cfg_t              pend_i,
  input  cfg_t              act_i,
  output logic [NUM_CH-1:0] samp_o,
  output logic              conv_o,
  output logic [CH_W-1:0]   mux_sel_o
);
  localparam int PH_W = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;

  logic            run_q;
  logic [PH_W-1:0] ph_q;
  logic [CH_W-1:0] slot_q;
  logic            slot_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      ph_q   <= '0;
      slot_q <= '0;
    end else if (sync_i) begin
      run_q  <= !pend_i.standby;
      ph_q   <= '0;
      slot_q <= '0;
    end else if (run_q) begin
      if (ph_q == PH_W'(SLOT_CYC-1)) begin
        ph_q <= '0;
        if (!act_i.mono) begin
          if (slot_q == CH_W'(NUM_CH-1)) begin
            run_q  <= 1'b0;
            slot_q <= '0;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  assign slot_go   = run_q && (ph_q == '0) && !act_i.standby;
  assign conv_o    = slot_go;
  assign mux_sel_o = act_i.mono ? act_i.mono_ch : slot_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_samp
    assign samp_o[c] = act_i.mono ? (slot_go && act_i.mono_ch == CH_W'(c))
                                  : (slot_go && slot_q == '0);
  end

  // R4
  no_back2back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_o && !sync_i |=> !conv_o);
  // R8
  standby_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.standby |-> (!conv_o && samp_o == '0));
  // R6
  mono_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.mono |-> $onehot0(samp_o));
  // R2
  colour_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_i.mono && samp_o != '0) |-> ($countones(samp_o) == NUM_CH && mux_sel_o == '0));
  // R3
  sample_has_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_o != '0 |-> conv_o);
endmodule

// File: rtl/pxseq_fmt.sv
module pxseq_fmt
  import pxseq_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              invert_i,
  input  logic              conv_i,
  input  logic [CH_W-1:0]   mux_i,
  input  logic              adc_valid_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [CH_W-1:0]   tag_o
);
  logic [CH_W-1:0] last_q, cur_ch;

  assign cur_ch = conv_i ? mux_i : last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
      tag_o   <= '0;
    end else begin
      last_q  <= cur_ch;
      valid_o <= adc_valid_i;
      if (adc_valid_i) begin
        data_o <= invert_i ? ~adc_data_i : adc_data_i;
        tag_o  <= cur_ch;
      end
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_valid_i |=> valid_o);
  // R10
  tag_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> tag_o <= CH_W'(NUM_CH-1));
endmodule

// File: rtl/pxseq_top.sv
module pxseq_top
  import pxseq_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int SLOT_CYC = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              cfg_we_i,
  input  logic [5:0]        cfg_wdata_i,
  input  logic              adc_valid_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic [2:0]        samp_o,
  output logic              conv_o,
  output logic [1:0]        mux_sel_o,
  output logic              cds_o,
  output logic              data_valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [1:0]        data_tag_o
);
  cfg_t pend, act;

  pxseq_cfg i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sync_i  (sync_i),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_t'(cfg_wdata_i)),
    .pend_o  (pend),
    .act_o   (act)
  );

  pxseq_timer #(.SLOT_CYC(SLOT_CYC)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_i),
    .pend_i    (pend),
    .act_i     (act),
    .samp_o    (samp_o),
    .conv_o    (conv_o),
    .mux_sel_o (mux_sel_o)
  );

  pxseq_fmt #(.DATA_W(DATA_W)) i_fmt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .invert_i    (act.invert),
    .conv_i      (conv_o),
    .mux_i       (mux_sel_o),
    .adc_valid_i (adc_valid_i),
    .adc_data_i  (adc_data_i),
    .valid_o     (data_valid_o),
    .data_o      (data_o),
    .tag_o       (data_tag_o)
  );

  assign cds_o = act.cds;

  // R2
  sync_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !pend.standby) |=> (conv_o && samp_o != '0));
  // R5
  sync_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !pend.standby && !pend.mono) |=> (samp_o == 3'b111 && mux_sel_o == 2'd0));
endmodule

// File: tb/test_pxseq_top.sv
`timescale 1ns/1ps
module test_pxseq_top;
  localparam int DW = 12;

  logic          clk_i = 1'b0, rst_ni = 1'b0, sync_i = 1'b0, cfg_we_i = 1'b0;
  logic [5:0]    cfg_wdata_i = '0;
  logic          adc_valid_i = 1'b0;
  logic [DW-1:0] adc_data_i = '0;
  logic [2:0]    samp_o;
  logic          conv_o, cds_o, data_valid_o;
  logic [1:0]    mux_sel_o, data_tag_o;
  logic [DW-1:0] data_o;

  pxseq_top #(.DATA_W(DW), .SLOT_CYC(2)) i_pxseq_top (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // bench model: position counted from sync
  logic [5:0]    m_pend = '0, m_act = '0;
  bit            m_run = 0;
  int            m_pos = 0;
  int            m_last = 0, m_tag = 0;
  bit            m_valid = 0;
  logic [DW-1:0] m_data = '0;
  int            e_samp = 0, e_mux = 0;
  bit            e_conv = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [5:0] fix_cfg(input logic [5:0] w);
    logic [5:0] r = w;
    if (w[2:1] == 2'd3) r[2:1] = 2'd2;
    return r;
  endfunction

  function automatic void mdl_expect();
    bit mono = m_act[0];
    int ch = int'(m_act[2:1]);
    e_conv = m_run && (m_pos % 2 == 0);
    if (mono) begin
      e_mux  = ch;
      e_samp = e_conv ? (1 << ch) : 0;
    end else begin
      e_mux  = m_run ? m_pos / 2 : 0;
      e_samp = (m_run && m_pos == 0) ? 7 : 0;
    end
  endfunction

  function automatic void mdl_step(input bit s, input bit we, input logic [5:0] wd,
                                   input bit av, input logic [DW-1:0] ad);
    int cur = e_conv ? e_mux : m_last;
    m_valid = av;
    if (av) begin
      m_data = m_act[3] ? ~ad : ad;
      m_tag  = cur;
    end
    m_last = cur;
    if (s) begin
      m_act = m_pend;
      m_run = !m_pend[4];
      m_pos = 0;
    end else if (m_run) begin
      m_pos++;
      if (!m_act[0] && m_pos > 5) m_run = 0;
    end
    if (we) m_pend = fix_cfg(wd);
    mdl_expect();
  endfunction

  task automatic compare();
    chk(samp_o == 3'(e_samp), "samp", int'(samp_o), e_samp);
    chk(conv_o == e_conv, "conv", int'(conv_o), int'(e_conv));
    chk(mux_sel_o == 2'(e_mux), "mux", int'(mux_sel_o), e_mux);
    chk(cds_o == m_act[5], "cds", int'(cds_o), int'(m_act[5]));
    chk(data_valid_o == m_valid, "valid", int'(data_valid_o), int'(m_valid));
    if (m_valid) begin
      chk(data_o == m_data, "data", int'(data_o), int'(m_data));
      chk(data_tag_o == 2'(m_tag), "tag", int'(data_tag_o), m_tag);
    end
  endtask

  task automatic cyc(input bit s, input bit we, input logic [5:0] wd,
                     input bit av, input logic [DW-1:0] ad);
    sync_i = s; cfg_we_i = we; cfg_wdata_i = wd; adc_valid_i = av; adc_data_i = ad;
    @(posedge clk_i);
    mdl_step(s, we, wd, av, ad);
    #1;
    compare();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, '0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    mdl_expect();
    repeat (3) @(posedge clk_i);
    #1;
    // R1 reset state
    cur_req = "R1";
    compare();
    chk(conv_o == 0 && samp_o == 0 && data_valid_o == 0, "reset_idle", int'(conv_o), 0);
    rst_ni = 1'b1;
    idle(2);

    // R2 colour sync response
    cur_req = "R2";
    cyc(1, 0, '0, 0, '0);
    chk(samp_o == 3'b111 && conv_o && mux_sel_o == 0, "first_cycle", int'(samp_o), 7);
    // R3 order and idle; R4 spacing
    cur_req = "R3";
    cyc(0, 0, '0, 0, '0);
    cyc(0, 0, '0, 0, '0);
    chk(conv_o && mux_sel_o == 2'd1, "green_slot", int'(mux_sel_o), 1);
    idle(3);
    cur_req = "R4";
    cyc(0, 0, '0, 0, '0);
    chk(!conv_o && samp_o == 0, "post_seq_idle", int'(conv_o), 0);

    // R5 mid-sequence resync
    cur_req = "R5";
    cyc(1, 0, '0, 0, '0);
    idle(3);
    cyc(1, 0, '0, 0, '0);
    chk(samp_o == 3'b111 && mux_sel_o == 0 && conv_o, "restart", int'(mux_sel_o), 0);
    idle(6);

    // R7 write mid-pixel, R12 field layout: mono ch1
    cur_req = "R7";
    cyc(1, 0, '0, 0, '0);
    cyc(0, 1, 6'b000011, 0, '0);
    cyc(0, 0, '0, 0, '0);
    chk(mux_sel_o == 2'd1 && samp_o == 0, "still_colour", int'(samp_o), 0);
    cyc(0, 0, '0, 0, '0);
    cyc(0, 0, '0, 0, '0);
    chk(mux_sel_o == 2'd2 && conv_o, "blue_kept", int'(mux_sel_o), 2);

    // R6 mono stream, channel field 3 clamps to 2
    cur_req = "R6";
    cyc(1, 1, 6'b000111, 0, '0);
    chk(samp_o == 3'b010 && mux_sel_o == 2'd1, "mono_ch1", int'(samp_o), 2);
    idle(9);
    cur_req = "R12";
    cyc(1, 0, '0, 0, '0);
    chk(samp_o == 3'b100 && mux_sel_o == 2'd2, "mono_clamp", int'(mux_sel_o), 2);
    idle(7);

    // R11 cds
    cur_req = "R11";
    cyc(0, 1, 6'b100000, 0, '0);
    chk(cds_o == 1'b0, "cds_pending", int'(cds_o), 0);
    cyc(1, 0, '0, 0, '0);
    chk(cds_o == 1'b1, "cds_applied", int'(cds_o), 1);
    idle(6);

    // R8 standby
    cur_req = "R8";
    cyc(0, 1, 6'b010000, 0, '0);
    cyc(1, 0, '0, 0, '0);
    chk(!conv_o && samp_o == 0, "standby_quiet", int'(conv_o), 0);
    idle(4);

    // R9 inversion
    cur_req = "R9";
    cyc(0, 1, 6'b001000, 0, '0);
    cyc(1, 0, '0, 0, '0);
    cyc(0, 0, '0, 1, 12'h0F0);
    chk(data_valid_o && data_o == 12'hF0F, "inverted", int'(data_o), 'hF0F);
    // R10 tag with return in the conversion cycle of green
    cur_req = "R10";
    cyc(0, 0, '0, 0, '0);
    cyc(0, 0, '0, 1, 12'h123);
    chk(data_tag_o == 2'd1, "tag_same_cycle", int'(data_tag_o), 1);
    idle(4);

    // random mix
    cur_req = "R4";
    for (int i = 0; i < 4000; i++) begin
      bit s   = ($urandom % 9) == 0;
      bit we  = ($urandom % 15) == 0;
      logic [5:0] wd = 6'($urandom);
      bit av  = ($urandom % 3) == 0;
      if (($urandom % 4) != 0) wd[4] = 1'b0;
      cyc(s, we, wd, av, DW'($urandom));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule